// File: doc/BRIEF.md
# TDM Frame Serializer

This block turns 32 parallel byte sources into one serial time-division multiplexed stream. A frame lasts 256 bit times. Each of the 32 timeslots carries one byte. An internal 8-bit counter advances once for every pulse of a bit-rate clock enable. Its low three bits give the position within the current timeslot, and its high five bits give the timeslot number.

During the last bit of each timeslot, the shift register loads the byte for the following timeslot. The upper counter bits pick which source supplies that byte. The block never sends a byte of all zeros: a zero source byte goes out as binary 00000010, so the line always carries some ones. The block also outputs a frame sync strobe on the final bit time of each frame and the index of the current timeslot. It is meant to run from a fast system clock, with `bit_en` pulsing at the line rate.

Top module: `tdm_framer`

## Requirements
- R1: `slot_idx` equals the upper five bits of a bit counter. The counter advances by one on each clock edge where `bit_en` is high. It wraps from 255 to 0, so `slot_idx` goes 0..31 and then back to 0.
- R2: `frame_sync` is high exactly while the bit counter equals 255, which is the last bit of timeslot 31. It is low at every other count.
- R3: Bits go out most significant bit first. While the counter is in bit position b (0..7) of a timeslot, `ser_out` equals bit 7-b of the byte sent in that timeslot.
- R4: Timeslot s sends source byte s, held in `src_bytes[8*s+7:8*s]`. The byte is taken from the value present on the enabled edge that ends bit 7 of slot s-1, and slot 0 takes its byte at the end of slot 31. Changes to that source after this edge have no effect on the byte being sent.
- R5: A source byte of 8'h00 is sent as 8'h02. Every other value, including 8'h02, is sent unchanged.
- R6: While `bit_en` is low, `slot_idx`, `frame_sync` and `ser_out` keep their values.
- R7: A synchronous active-high `rst` clears the counter and the shift register, even when `bit_en` is high. After reset, `slot_idx` is 0 and `frame_sync` is 0. Slot 0 of the first frame after reset sends all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate clock enable |
| src_bytes | input | 256 | 32 source bytes; slot s occupies bits 8*s+7 down to 8*s |
| ser_out | output | 1 | Serial data, MSB first |
| frame_sync | output | 1 | High during the last bit time of a frame |
| slot_idx | output | 5 | Current timeslot number |

## Verification
The bench goes after the timeslot 31 to 0 wrap. A design that computes the next slot without wrapping would send the wrong source byte in slot 0. It also gets `frame_sync` wrong, either a cycle early or a cycle late. Sources are changed randomly after their byte has been loaded, to catch a design that reads the source live instead of latching it at bit 7; such a design would corrupt the later bits of a slot. Zero bytes and literal 8'h02 bytes are both sent. This exposes a substitution that is missing, or one that also rewrites other values. Gaps in `bit_en` and a reset asserted mid-frame with the enable high show whether the design keeps advancing when it should hold, and whether reset loses to the enable.

// File: rtl/tdm_framer.sv
module tdm_framer #(
  parameter int SLOTS = 32,
  parameter int W = 8,
  parameter logic [W-1:0] SUB_BYTE = W'(2)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_en,
  input  logic [SLOTS*W-1:0]       src_bytes,
  output logic                     ser_out,
  output logic                     frame_sync,
  output logic [$clog2(SLOTS)-1:0] slot_idx
);
  localparam int PW = $clog2(W);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = PW + SW;

  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic [SW-1:0] nxt;
  logic [W-1:0]  fetched;
  logic [W-1:0]  coded;
  logic          last_bit;

  assign last_bit   = &cnt[PW-1:0];
  assign slot_idx   = cnt[CW-1:PW];
  assign nxt        = slot_idx + 1'b1;
  assign fetched    = src_bytes[nxt*W +: W];
  assign coded      = (fetched == '0) ? SUB_BYTE : fetched;
  assign ser_out    = shreg[W-1];
  assign frame_sync = &cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (bit_en) begin
      cnt   <= cnt + 1'b1;
      shreg <= last_bit ? coded : {shreg[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/tdm_framer_chk.sv
module tdm_framer_chk #(
  parameter int SLOTS = 32,
  parameter int W = 8
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 bit_en,
  input logic                                 ser_out,
  input logic                                 frame_sync,
  input logic [$clog2(SLOTS)-1:0]             slot_idx,
  input logic [$clog2(SLOTS)+$clog2(W)-1:0]   cnt,
  input logic [W-1:0]                         shreg
);
  localparam int PW = $clog2(W);
  localparam int SW = $clog2(SLOTS);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(slot_idx) && $stable(ser_out) && $stable(frame_sync));

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && frame_sync) |=> slot_idx == '0);

  p_sync_slot_r2: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> (slot_idx == SW'(SLOTS-1)) && (&cnt[PW-1:0]));

  p_no_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && (&cnt[PW-1:0])) |=> shreg != '0);

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !ser_out && !frame_sync);
endmodule

bind tdm_framer tdm_framer_chk #(.SLOTS(SLOTS), .W(W)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .ser_out(ser_out),
  .frame_sync(frame_sync), .slot_idx(slot_idx), .cnt(cnt), .shreg(shreg)
);

// File: tb/tb_tdm_framer.sv
module tb_tdm_framer;
  localparam int CLK_NS = 10;
  localparam int SLOTS = 32;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic [SLOTS*W-1:0] src_bytes = '0;
  logic ser_out, frame_sync;
  logic [4:0] slot_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] mcnt = 8'd0;
  logic [7:0] mbyte = 8'd0;
  bit mzero = 0;
  bit last_en = 0;
  bit mod_since [SLOTS];

  tdm_framer dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .src_bytes(src_bytes),
    .ser_out(ser_out), .frame_sync(frame_sync), .slot_idx(slot_idx)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] line_byte(input logic [7:0] b);
    return (b == 8'h00) ? 8'h02 : b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h cnt=%0d", tag, act, exp, mcnt);
    end
  endtask

  task automatic check_all();
    string st;
    chk(last_en ? "R1" : "R6", int'(slot_idx), int'(mcnt[7:3]));
    chk("R2", int'(frame_sync), int'(mcnt == 8'd255));
    if (mzero) st = "R5";
    else if (mod_since[mcnt[7:3]]) st = "R4";
    else st = "R3";
    chk(st, int'(ser_out), int'(mbyte[7 - int'(mcnt[2:0])]));
  endtask

  task automatic set_src(input int s, input logic [7:0] v);
    src_bytes[s*8 +: 8] = v;
    mod_since[s] = 1;
  endtask

  task automatic step(input bit en);
    bit_en = en;
    if (en) begin
      if (mcnt[2:0] == 3'd7) begin
        logic [4:0] nx;
        nx = mcnt[7:3] + 5'd1;
        mbyte = line_byte(src_bytes[int'(nx)*8 +: 8]);
        mzero = (src_bytes[int'(nx)*8 +: 8] == 8'h00);
        mod_since[nx] = 0;
      end
      mcnt = mcnt + 8'd1;
    end
    last_en = en;
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_en = 1'b1;
    mcnt = 8'd0;
    mbyte = 8'd0;
    mzero = 0;
    for (int s = 0; s < SLOTS; s++) mod_since[s] = 0;
    @(negedge clk);
    chk("R7", int'(slot_idx), 0);
    chk("R7", int'(frame_sync), 0);
    chk("R7", int'(ser_out), 0);
    rst = 1'b0;
    bit_en = 1'b0;
    last_en = 1;
  endtask

  task automatic random_steps(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(15) == 0) begin
        int s;
        s = $urandom_range(SLOTS-1);
        set_src(s, ($urandom_range(3) == 0) ? 8'h00 : 8'($urandom));
      end
      step($urandom_range(9) < 7);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < SLOTS; s++) src_bytes[s*8 +: 8] = 8'($urandom);
    src_bytes[0*8 +: 8]  = 8'h00;
    src_bytes[1*8 +: 8]  = 8'h80;
    src_bytes[5*8 +: 8]  = 8'h02;
    src_bytes[9*8 +: 8]  = 8'h00;
    src_bytes[31*8 +: 8] = 8'hFF;
    @(negedge clk);
    do_reset();
    // directed: two full frames with enable always high, covers the 31 -> 0 wrap
    for (int i = 0; i < 512; i++) step(1'b1);
    // enable gaps
    for (int i = 0; i < 5; i++) step(1'b0);
    random_steps(900);
    // reset mid-frame with enable high
    do_reset();
    random_steps(700);
    for (int i = 0; i < 300; i++) step(1'b1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule